// File: doc/BRIEF.md
# Serial Converter Slave Port

This block is the 16-bit serial port through which a data converter exchanges words with a host controller. The host drives the serial clock, an active-low frame sync and the serial input line. The block returns a serial output line together with a separate enable that says when that line should leave high impedance. Each frame is a full-duplex exchange. The word loaded on the parallel transmit input goes out most significant bit first, and the word shifted in from the host comes back on a parallel output with a one-cycle valid strobe.

The block supports two framing styles, chosen by a mode input. In level framing, the frame lasts while sync is low. Sync may be pulsed once per frame, or held low so that consecutive groups of 16 clocks form consecutive frames. In edge framing, a falling sync edge starts a frame, and an internal count closes it after 16 clocks, whatever sync does after the first clock. A polarity input selects which serial clock edge shifts data out and which edge samples data in.

The serial lines are brought into the system clock domain through a synchronizer of configurable depth, and the framing logic is a plain synchronous design. The serial clock must stay low and high for at least the synchronizer depth plus two system clocks on each half period.

Top module: `sconv_serial_slave`

## Requirements
- R1: A frame moves exactly 16 bits in each direction, most significant bit first. After the 16th sampling edge, the received word appears on `rx_word` with `rx_valid` high for exactly one system clock.
- R2: In level framing (`mode`=0), `dout_oe` is high while `sync_n` is low and goes low once `sync_n` is high.
- R3: With `polarity`=0, a falling serial clock edge shifts out the next transmit bit and a rising edge samples `din`. The first falling edge after the frame starts puts bit 15 of the transmit word on `dout`.
- R4: With `polarity`=1, the edges are swapped: rising edges shift data out and falling edges sample `din`. The first rising edge puts bit 15 on `dout`.
- R5: In level framing with `sync_n` held low, each further group of 16 clocks is a new frame. Each such frame returns its own `rx_valid` pulse and sends the transmit word present at the boundary between frames.
- R6: The transmit word is captured when the frame starts (or at the boundary between frames, as in R5). Changes to `tx_word` during a frame do not change the bits sent in that frame.
- R7: In level framing, if `sync_n` rises before the 16th sampling edge, the partial frame is dropped: no `rx_valid` pulse occurs and `dout_oe` goes low.
- R8: In edge framing (`mode`=1), a falling edge on `sync_n` starts a frame of 16 clocks. `sync_n` may rise at any time after the first clock without shortening the frame. `dout_oe` is high from the start of the frame until the 16th sampling edge and low afterwards.
- R9: Raising `sync_n` and then lowering it again clears the bit count and starts a new frame, in both framing styles. Only a frame that then runs to 16 bits produces `rx_valid`.
- R10: After reset, `dout_oe`, `dout`, `rx_valid` and `rx_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| sync_n | input | 1 | Active-low frame sync from the host |
| din | input | 1 | Serial data from the host |
| mode | input | 1 | 0 = level framing, 1 = edge framing |
| polarity | input | 1 | 0 = shift on falling, sample on rising; 1 = swapped |
| tx_word | input | 16 | Parallel word to transmit |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | High when `dout` should be driven |
| rx_word | output | 16 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |

## Verification
Pulsed level frames with random host and slave words, including words that differ only in their end bits, confirm the bit order in both directions and rule out any off-by-one in the count. Back-to-back frames with sync held low show that the count wraps correctly and the transmit word is reloaded at each boundary. Truncated level frames, and edge frames where sync rises early or is re-lowered partway through, separate the discard, restart and counted-length rules. Both polarities run in both framing styles to show that the edge swap applies to the input and the output together.

// File: rtl/sconv_slave_pkg.sv
package sconv_slave_pkg;

    typedef enum logic {
        FRAME_LEVEL = 1'b0,
        FRAME_EDGE  = 1'b1
    } frame_mode_e;

    // Serial line events in the system clock domain
    typedef struct packed {
        logic sample;     // edge on which din is taken
        logic shift;      // edge on which dout advances
        logic sync_low;   // synchronized sync level is low
        logic sync_fell;  // sync high-to-low transition
        logic din;        // synchronized serial input
    } line_events_t;

    // Frame control strobes handed to the datapath
    typedef struct packed {
        logic start;   // new frame begins, transmit word captured
        logic reload;  // back-to-back frame boundary with sync held low
        logic last;    // 16th sampling edge of a frame
        logic active;  // frame in progress
    } frame_ctl_t;

    // Choose the edge of interest for a given polarity setting
    function automatic logic pick_edge(input logic rise, input logic fall, input logic swap);
        return swap ? fall : rise;
    endfunction

endpackage

// File: rtl/sconv_line_cond.sv
module sconv_line_cond
    import sconv_slave_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk,
    input  logic         sync_n,
    input  logic         din,
    input  logic         polarity,
    output line_events_t ev
);

    typedef struct packed {
        logic sck;
        logic syn;
        logic dat;
    } line_t;

    line_t                     raw;
    line_t [STAGES-1:0]        stg;
    line_t                     cur;
    line_t                     prev;
    logic                      sck_rise;
    logic                      sck_fall;

    assign raw = '{sck: sclk, syn: sync_n, dat: din};

    // Synchronizer chain; on reset it loads the live levels so no false edge appears
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= raw;
            prev <= raw;
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign cur      = stg[STAGES-1];
    assign sck_rise = cur.sck & ~prev.sck;
    assign sck_fall = ~cur.sck & prev.sck;

    always_comb begin
        ev.sample    = pick_edge(sck_rise, sck_fall, polarity);
        ev.shift     = pick_edge(sck_fall, sck_rise, polarity);
        ev.sync_low  = ~cur.syn;
        ev.sync_fell = ~cur.syn & prev.syn;
        ev.din       = cur.dat;
    end

endmodule

// File: rtl/sconv_frame_ctl.sv
module sconv_frame_ctl
    import sconv_slave_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  frame_mode_e  mode,
    input  line_events_t ev,
    output frame_ctl_t   ctl,
    output logic         oe
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic             is_level;
    logic             start;
    logic             last;

    assign is_level = (mode == FRAME_LEVEL);

    // Level framing starts whenever sync is low and no frame is open;
    // edge framing starts (or restarts) on every falling sync edge.
    assign start = is_level ? (ev.sync_low & ~active) : ev.sync_fell;
    assign last  = active & ev.sample & ~start & (cnt == LAST_IDX)
                 & (~is_level | ev.sync_low);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (is_level & ~ev.sync_low) begin
            active <= 1'b0;
        end else if (active & ev.sample) begin
            if (cnt == LAST_IDX) begin
                cnt    <= '0;
                active <= is_level;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        ctl.start  = start;
        ctl.reload = last & is_level;
        ctl.last   = last;
        ctl.active = active;
        oe         = is_level ? ev.sync_low : active;
    end

    // A new frame always begins from bit zero
    assert_count_cleared_on_start_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == '0));

    // The bit count moves only on a sampling edge or a frame start
    assert_count_moves_on_sample_R1: assert property (@(posedge clk) disable iff (rst)
        (!ev.sample && !start) |=> $stable(cnt));

endmodule

// File: rtl/sconv_shift_path.sv
module sconv_shift_path
    import sconv_slave_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  line_events_t      ev,
    input  frame_ctl_t        ctl,
    input  logic [WORD_W-1:0] tx_word,
    output logic              dout,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);

    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] rx_next;

    assign rx_next = {rx_sh[WORD_W-2:0], ev.din};

    // Transmit side: capture at frame start or boundary, shift on the output edge
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
            dout  <= 1'b0;
        end else if (ctl.start) begin
            tx_sh <= tx_word;
            dout  <= 1'b0;
        end else if (ctl.reload) begin
            tx_sh <= tx_word;
        end else if (ctl.active & ev.shift) begin
            dout  <= tx_sh[WORD_W-1];
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        end
    end

    // Receive side: shift on the sampling edge, publish on the last bit
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= ctl.last;
            if (ctl.active & ev.sample & ~ctl.start) rx_sh <= rx_next;
            if (ctl.last) rx_word <= rx_next;
        end
    end

    // The valid strobe never lasts more than one cycle
    assert_valid_single_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // The received word changes only together with the valid strobe
    assert_rx_word_held_R1: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_word));

endmodule

// File: rtl/sconv_serial_slave.sv
module sconv_serial_slave
    import sconv_slave_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              din,
    input  logic              mode,
    input  logic              polarity,
    input  logic [WORD_W-1:0] tx_word,
    output logic              dout,
    output logic              dout_oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);

    line_events_t ev;
    frame_ctl_t   ctl;
    frame_mode_e  mode_e;

    assign mode_e = frame_mode_e'(mode);

    sconv_line_cond #(
        .STAGES (SYNC_STAGES)
    ) u_line (
        .clk      (clk),
        .rst      (rst),
        .sclk     (sclk),
        .sync_n   (sync_n),
        .din      (din),
        .polarity (polarity),
        .ev       (ev)
    );

    sconv_frame_ctl #(
        .WORD_W (WORD_W)
    ) u_ctl (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_e),
        .ev   (ev),
        .ctl  (ctl),
        .oe   (dout_oe)
    );

    sconv_shift_path #(
        .WORD_W (WORD_W)
    ) u_path (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .ctl      (ctl),
        .tx_word  (tx_word),
        .dout     (dout),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    // Level framing: a high sync keeps the output in high impedance
    assert_level_oe_off_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_e == FRAME_LEVEL && !ev.sync_low) |-> !dout_oe);

    // Edge framing: an open frame keeps driving until its last bit or a restart
    assert_edge_oe_held_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_e == FRAME_EDGE && dout_oe && !ctl.last && !ev.sync_fell) |=> dout_oe);

    // Level framing: a frame closed by sync never reports a word
    assert_discard_no_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_e == FRAME_LEVEL && !ev.sync_low) |=> !rx_valid);

endmodule

// File: tb/test_sconv_serial_slave.sv
`timescale 1ns/1ps
module test_sconv_serial_slave;

    localparam int W = 16;
    localparam int H = 6;  // system clocks per serial half period

    logic         clk = 1'b0;
    logic         rst;
    logic         sclk, sync_n, din, mode, polarity;
    logic [W-1:0] tx_word;
    logic         dout, dout_oe, rx_valid;
    logic [W-1:0] rx_word;

    int           checks = 0;
    int           errors = 0;
    int           vcount = 0;
    logic [W-1:0] vlog [64];
    logic         done = 1'b0;

    always #2.5 clk = ~clk;

    sconv_serial_slave #(.WORD_W(W), .SYNC_STAGES(2)) i_sconv_serial_slave (
        .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .din(din),
        .mode(mode), .polarity(polarity), .tx_word(tx_word),
        .dout(dout), .dout_oe(dout_oe), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    // Record every received word
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (vcount < 64) vlog[vcount] = rx_word;
            vcount = vcount + 1;
        end
    end

    function automatic logic shift_level(input logic pol);
        return pol;  // pol 0: falling edge shifts (go low); pol 1: rising shifts (go high)
    endfunction

    function automatic logic idle_level(input logic pol);
        return ~pol;
    endfunction

    function automatic logic exp_level_oe(input logic sync_level);
        return ~sync_level;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nbits; raise_at >= 0 lifts sync after that bit's sample edge.
    // next_tx is placed on tx_word during the last bit, junk is placed at bit 3.
    task automatic run_frame(input logic [W-1:0] mword, input int nbits, input int raise_at,
                             input logic [W-1:0] next_tx,
                             output logic [W-1:0] got, output logic oe_ok);
        got   = '0;
        oe_ok = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            sclk = shift_level(polarity);
            din  = mword[W-1-i];
            wait_clk(H);
            got = {got[W-2:0], dout};
            if (!dout_oe) oe_ok = 1'b0;
            if (i == 3) tx_word = W'($urandom);
            if (i == W-1) tx_word = next_tx;
            sclk = idle_level(polarity);
            wait_clk(H);
            if (i == raise_at) sync_n = 1'b1;
        end
    endtask

    task automatic set_config(input logic m, input logic p);
        sync_n   = 1'b1;
        wait_clk(H);
        mode     = m;
        polarity = p;
        sclk     = idle_level(p);
        wait_clk(H);
    endtask

    // Pulsed level frame with full checks
    task automatic level_frame(input logic [W-1:0] mword, input logic [W-1:0] tword, input string req);
        logic [W-1:0] got;
        logic         oe_ok;
        int           v0;
        v0      = vcount;
        tx_word = tword;
        sync_n  = 1'b0;
        wait_clk(H);
        chk(dout_oe == exp_level_oe(1'b0), "R2 oe on with sync low", W'(dout_oe), W'(1));
        run_frame(mword, W, -1, W'($urandom), got, oe_ok);
        chk(got == tword, {req, " R6 transmitted word"}, got, tword);
        chk(vcount == v0 + 1, "R1 one valid per frame", W'(vcount - v0), W'(1));
        chk(vlog[v0] == mword, "R1 received word", vlog[v0], mword);
        sync_n = 1'b1;
        wait_clk(4);
        chk(dout_oe == exp_level_oe(1'b1), "R2 oe off with sync high", W'(dout_oe), W'(0));
    endtask

    // Edge frame where sync rises after bit raise_at
    task automatic edge_frame(input logic [W-1:0] mword, input logic [W-1:0] tword, input int raise_at, input string req);
        logic [W-1:0] got;
        logic         oe_ok;
        int           v0;
        v0      = vcount;
        tx_word = tword;
        sync_n  = 1'b0;
        wait_clk(H);
        run_frame(mword, W, raise_at, W'($urandom), got, oe_ok);
        chk(oe_ok, "R8 oe held for whole counted frame", W'(oe_ok), W'(1));
        chk(got == tword, {req, " R8 transmitted word"}, got, tword);
        chk(vcount == v0 + 1, "R8 one valid per counted frame", W'(vcount - v0), W'(1));
        chk(vlog[v0] == mword, "R8 received word", vlog[v0], mword);
        chk(dout_oe == 1'b0, "R8 oe off after 16th bit", W'(dout_oe), W'(0));
        sync_n = 1'b1;
        wait_clk(H);
    endtask

    initial begin
        wait_clk(100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] got, t0, t1, t2, m0, m1, m2;
        logic         oe_ok;
        int           v0;
        void'($urandom(32'd1234));

        rst = 1'b1; sclk = 1'b1; sync_n = 1'b1; din = 1'b0;
        mode = 1'b0; polarity = 1'b0; tx_word = '0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R10 reset state
        chk(dout_oe == 1'b0, "R10 oe after reset", W'(dout_oe), W'(0));
        chk(dout == 1'b0, "R10 dout after reset", W'(dout), W'(0));
        chk(rx_valid == 1'b0, "R10 valid after reset", W'(rx_valid), W'(0));
        chk(rx_word == '0, "R10 rx_word after reset", rx_word, '0);

        // R3 directed end-bit patterns, then random, polarity 0 level framing
        level_frame(16'h8001, 16'h7FFE, "R3");
        level_frame(16'h7FFE, 16'h8001, "R3");
        for (int k = 0; k < 4; k++) level_frame(W'($urandom), W'($urandom), "R3");

        // R7 truncated level frame, then R9 fresh frame
        v0 = vcount;
        tx_word = W'($urandom);
        sync_n = 1'b0;
        wait_clk(H);
        run_frame(W'($urandom), 7, -1, '0, got, oe_ok);
        sync_n = 1'b1;
        wait_clk(H);
        chk(vcount == v0, "R7 truncated frame gives no valid", W'(vcount - v0), W'(0));
        chk(dout_oe == 1'b0, "R7 oe off after truncation", W'(dout_oe), W'(0));
        level_frame(W'($urandom), W'($urandom), "R9");

        // R5 sync held low across three back-to-back frames
        t0 = W'($urandom); t1 = W'($urandom); t2 = W'($urandom);
        m0 = W'($urandom); m1 = W'($urandom); m2 = W'($urandom);
        v0 = vcount;
        tx_word = t0;
        sync_n = 1'b0;
        wait_clk(H);
        run_frame(m0, W, -1, t1, got, oe_ok);
        chk(got == t0, "R5 first tied-low frame word", got, t0);
        run_frame(m1, W, -1, t2, got, oe_ok);
        chk(got == t1, "R5 second tied-low frame word", got, t1);
        run_frame(m2, W, -1, W'($urandom), got, oe_ok);
        chk(got == t2, "R5 third tied-low frame word", got, t2);
        chk(oe_ok, "R5 oe held across frames", W'(oe_ok), W'(1));
        chk(vcount == v0 + 3, "R5 three valid strobes", W'(vcount - v0), W'(3));
        chk(vlog[v0] == m0 && vlog[v0+1] == m1 && vlog[v0+2] == m2, "R5 received words",
            vlog[v0+2], m2);

        // R4 swapped polarity, level framing
        set_config(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) level_frame(W'($urandom), W'($urandom), "R4");

        // R8 edge framing, sync raised after the first bit, polarity 1
        set_config(1'b1, 1'b1);
        edge_frame(W'($urandom), W'($urandom), 0, "R4");

        // R9 edge restart: 5 bits, sync high then low, full frame counts from new edge
        v0 = vcount;
        tx_word = W'($urandom);
        sync_n = 1'b0;
        wait_clk(H);
        run_frame(W'($urandom), 5, 0, '0, got, oe_ok);
        chk(dout_oe == 1'b1, "R8 oe kept after sync rises", W'(dout_oe), W'(1));
        t0 = W'($urandom);
        m0 = W'($urandom);
        tx_word = t0;
        sync_n = 1'b0;
        wait_clk(H);
        run_frame(m0, W, 2, W'($urandom), got, oe_ok);
        chk(got == t0, "R9 restarted frame word", got, t0);
        chk(vcount == v0 + 1, "R9 single valid after restart", W'(vcount - v0), W'(1));
        chk(vlog[v0] == m0, "R9 restarted received word", vlog[v0], m0);
        sync_n = 1'b1;
        wait_clk(H);

        // Random mix of framing styles and polarities
        for (int k = 0; k < 8; k++) begin
            set_config(1'($urandom), 1'($urandom));
            if (mode) edge_frame(W'($urandom), W'($urandom), int'($urandom % 15), "R8");
            else      level_frame(W'($urandom), W'($urandom), "R1");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule